// File: doc/BRIEF.md
# Gray-Pointer Dual-Clock FIFO

This block moves a stream of data words from one clock domain into another when the two clocks are unrelated in frequency and phase. A producer in the write domain presents a word and a write enable. The word is stored unless the buffer reports full. A consumer in the read domain raises a read enable. It gets the oldest stored word on the next read-clock edge unless the buffer reports empty. Storage is a register array with one write port and one read port. Its depth is a power of two, and the word width is a parameter.

Each side keeps a binary position counter that is one bit wider than the storage address. It also registers a Gray-coded copy of that counter, and only the Gray copy crosses to the other side. The Gray copy passes through a chain of flip-flops clocked by the receiving domain. The receiver decodes it back to binary and compares it with its own binary counter. The write side raises full when the two counters differ only in their top bit. The read side raises empty when they are equal. The crossed value arrives late, so each flag can stay raised a few cycles longer than strictly needed. It is never cleared too soon.

Each domain has its own synchronous active-low reset. Both resets are expected to be applied together.

Top module: `gray_async_fifo`

## Requirements
- R1: After both resets, rd_empty is 1, wr_full is 0 and rd_data is 0.
- R2: Every word accepted on the write side is delivered exactly once on the read side, in the order written, for any ratio between the two clocks.
- R3: rd_data takes the oldest stored word on the read-clock edge that accepts a read (rd_en high while rd_empty is low). It then holds that value until the next accepted read.
- R4: With no reads, wr_full stays 0 after DEPTH-1 accepted writes. It is 1 right after the write-clock edge of the DEPTH-th accepted write.
- R5: A write attempted while wr_full is 1 changes nothing. No stored word is overwritten, and the word is never delivered.
- R6: A read attempted while rd_empty is 1 changes nothing. rd_data keeps its previous value, and the read position does not move.
- R7: Neither domain ever sees more than DEPTH words stored or fewer than zero. Full and empty may be raised early, but they are never raised late.
- R8: After a write into an empty buffer, rd_empty falls within SYNC_STAGES+1 read-clock cycles of the write edge. After a read from a full buffer, wr_full falls within SYNC_STAGES+1 write-clock cycles of the read edge.
- R9: The Gray-coded position that each side sends across changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous reset, active low |
| wr_en | input | 1 | Request to store wr_data on this edge |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | No free slot; writes are ignored |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous reset, active low |
| rd_en | input | 1 | Request to take the oldest word on this edge |
| rd_data | output | DATA_W | Last word taken, registered |
| rd_empty | output | 1 | Nothing stored; reads are ignored |

## Verification
A wrong position counter or a wrong Gray decode shows up at rd_data as a duplicated, skipped or reordered word. The reference queue flags this on the first read that follows the fault. A wrong full compare shows up as an overwritten word once the buffer wraps, so it is seen within one pass through the DEPTH slots. A synchronizer that is too slow or too fast shows up as a flag that clears late or early. The bench measures this directly against the SYNC_STAGES+1 bound. The clock ratios of 1:3, 3:1 and near 1:1 make sure both flags are driven to their limits under both a fast and a slow partner domain.

// File: rtl/afifo_pkg.sv
// Shared helpers for the dual-clock FIFO: Gray encode and decode on a
// fixed-width word; callers cast to and from their own pointer width.
package afifo_pkg;

    localparam int GRAY_MAX_W = 32;

    typedef logic [GRAY_MAX_W-1:0] gray_word_t;

    // Binary to reflected Gray code.
    function automatic gray_word_t bin_to_gray(input gray_word_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary, prefix XOR from the top bit.
    function automatic gray_word_t gray_to_bin(input gray_word_t g);
        gray_word_t b;
        b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
        for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
// Multi-flop synchronizer for a Gray-coded bus.
// Assumes: the input changes at most one bit per source edge, so each
// captured value is either the old or the new code. STAGES >= 2.
module afifo_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] q_r;
            if (s == 0) begin : g_first
                // First capture flop: samples the foreign-domain bus.
                always_ff @(posedge clk) begin
                    if (!rst_n) q_r <= '0;
                    else        q_r <= d;
                end
            end else begin : g_next
                // Further resolution flop in the receiving domain.
                always_ff @(posedge clk) begin
                    if (!rst_n) q_r <= '0;
                    else        q_r <= g_stage[s-1].q_r;
                end
            end
        end
    endgenerate

    assign q = g_stage[STAGES-1].q_r;

endmodule

// File: rtl/afifo_mem.sv
// Register-array storage with one write port (write clock) and one
// combinational read port.
// Assumes: the read side only reads slots that the write side has already filled.
module afifo_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int SLOTS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [SLOTS];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    // Present the slot at the read position.
    always_comb rdata = cells[raddr];

endmodule

// File: rtl/afifo_wr_ctrl.sv
// Write-side position keeper: binary and Gray counters, decode of the
// synchronized read position, and the full flag.
// Assumes: rd_gray_sync is already resynchronized to clk.
module afifo_wr_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W:0]   rd_gray_sync,
    output logic              full,
    output logic              accept,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   ptr_bin,
    output logic [ADDR_W:0]   ptr_gray,
    output logic [ADDR_W:0]   rd_bin_sync
);

    import afifo_pkg::*;

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] ptr_next;

    // Decode the crossed read position into binary.
    always_comb rd_bin_sync = PTR_W'(gray_to_bin(gray_word_t'(rd_gray_sync)));

    // Full when the counters differ only in the wrap bit.
    always_comb full = (ptr_bin == {~rd_bin_sync[ADDR_W], rd_bin_sync[ADDR_W-1:0]});

    // Accept, next position and slot address.
    always_comb begin
        accept   = wr_req & ~full;
        ptr_next = ptr_bin + PTR_W'(1);
        waddr    = ptr_bin[ADDR_W-1:0];
    end

    // Advance both counters on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
        end else if (accept) begin
            ptr_bin  <= ptr_next;
            ptr_gray <= PTR_W'(bin_to_gray(gray_word_t'(ptr_next)));
        end
    end

endmodule

// File: rtl/afifo_rd_ctrl.sv
// Read-side position keeper: binary and Gray counters, decode of the
// synchronized write position, the empty flag and the output register.
// Assumes: wr_gray_sync is already resynchronized to clk.
module afifo_rd_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W:0]   wr_gray_sync,
    input  logic [DATA_W-1:0] mem_q,
    output logic              empty,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W:0]   ptr_bin,
    output logic [ADDR_W:0]   ptr_gray,
    output logic [ADDR_W:0]   wr_bin_sync
);

    import afifo_pkg::*;

    localparam int PTR_W = ADDR_W + 1;

    logic             accept;
    logic [PTR_W-1:0] ptr_next;

    // Decode the crossed write position into binary.
    always_comb wr_bin_sync = PTR_W'(gray_to_bin(gray_word_t'(wr_gray_sync)));

    // Empty when both counters match exactly.
    always_comb empty = (ptr_bin == wr_bin_sync);

    // Accept, next position and slot address.
    always_comb begin
        accept   = rd_req & ~empty;
        ptr_next = ptr_bin + PTR_W'(1);
        raddr    = ptr_bin[ADDR_W-1:0];
    end

    // Advance counters and capture the word on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_bin  <= '0;
            ptr_gray <= '0;
            rd_data  <= '0;
        end else if (accept) begin
            ptr_bin  <= ptr_next;
            ptr_gray <= PTR_W'(bin_to_gray(gray_word_t'(ptr_next)));
            rd_data  <= mem_q;
        end
    end

endmodule

// File: rtl/gray_async_fifo.sv
// Dual-clock FIFO top. It joins the storage, the two position keepers and
// the two synchronizers that carry the Gray positions across.
// Assumes: DEPTH is a power of two (at least 2), and both resets are applied together.
module gray_async_fifo #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PTR_W  = ADDR_W + 1;

    logic              wr_accept;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] mem_q;
    logic [PTR_W-1:0]  wr_ptr_bin;
    logic [PTR_W-1:0]  wr_ptr_gray;
    logic [PTR_W-1:0]  rd_ptr_bin;
    logic [PTR_W-1:0]  rd_ptr_gray;
    logic [PTR_W-1:0]  wr_gray_in_rd;
    logic [PTR_W-1:0]  rd_gray_in_wr;
    logic [PTR_W-1:0]  wr_bin_in_rd;
    logic [PTR_W-1:0]  rd_bin_in_wr;

    afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wr_clk),
        .we    (wr_accept),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    afifo_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk          (wr_clk),
        .rst_n        (wr_rst_n),
        .wr_req       (wr_en),
        .rd_gray_sync (rd_gray_in_wr),
        .full         (wr_full),
        .accept       (wr_accept),
        .waddr        (wr_addr),
        .ptr_bin      (wr_ptr_bin),
        .ptr_gray     (wr_ptr_gray),
        .rd_bin_sync  (rd_bin_in_wr)
    );

    afifo_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rd_rst_n),
        .rd_req       (rd_en),
        .wr_gray_sync (wr_gray_in_rd),
        .mem_q        (mem_q),
        .empty        (rd_empty),
        .raddr        (rd_addr),
        .rd_data      (rd_data),
        .ptr_bin      (rd_ptr_bin),
        .ptr_gray     (rd_ptr_gray),
        .wr_bin_sync  (wr_bin_in_rd)
    );

    afifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_ptr_gray),
        .q     (wr_gray_in_rd)
    );

    afifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_ptr_gray),
        .q     (rd_gray_in_wr)
    );

endmodule

// File: rtl/afifo_chk.sv
// Protocol checker for gray_async_fifo, attached with bind. It watches the
// ports and the position counters that the two domains drive separately.
module afifo_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_full,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_en,
    input logic              rd_empty,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   wr_bin,
    input logic [ADDR_W:0]   wr_gray,
    input logic [ADDR_W:0]   rd_bin,
    input logic [ADDR_W:0]   rd_gray,
    input logic [ADDR_W:0]   rd_bin_w,
    input logic [ADDR_W:0]   wr_bin_r
);

    localparam int          PTR_W = ADDR_W + 1;
    localparam logic [ADDR_W:0] SLOTS = PTR_W'(1 << ADDR_W);

    // R9
    wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R9
    rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    // R7
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        PTR_W'(wr_bin - rd_bin_w) <= SLOTS);

    // R7
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        PTR_W'(wr_bin_r - rd_bin) <= SLOTS);

    // R5
    full_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_full) |=> $stable(wr_bin));

    // R6
    empty_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_en && rd_empty) |=> ($stable(rd_data) && $stable(rd_bin)));

endmodule

bind gray_async_fifo afifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_afifo_chk (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_empty (rd_empty),
    .rd_data  (rd_data),
    .wr_bin   (wr_ptr_bin),
    .wr_gray  (wr_ptr_gray),
    .rd_bin   (rd_ptr_bin),
    .rd_gray  (rd_ptr_gray),
    .rd_bin_w (rd_bin_in_wr),
    .wr_bin_r (wr_bin_in_rd)
);

// File: tb/gray_async_fifo_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural queue tracks every accepted word.
// Both clock domains are compared on every falling edge of their own clock.
module gray_async_fifo_bench;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int SYNC   = 2;

    logic              wr_clk   = 1'b0;
    logic              rd_clk   = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic              wr_en    = 1'b0;
    logic              rd_en    = 1'b0;
    logic [DATA_W-1:0] wr_data  = '0;
    logic              wr_full;
    logic              rd_empty;
    logic [DATA_W-1:0] rd_data;

    real rd_half = 10.5;
    int  checks = 0;
    int  errors = 0;
    int  wr_seq = 0;
    int  wr_cyc = 0;
    bit  done   = 1'b0;

    logic [DATA_W-1:0] model_q [$];
    logic              full_prev  = 1'b0;
    logic              empty_prev = 1'b1;
    logic [DATA_W-1:0] data_prev  = '0;

    gray_async_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) u_gray_async_fifo (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    // 50 MHz write clock; the read clock period is set per phase.
    always #10 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Write-side model: record words the design accepted on the last edge.
    always @(negedge wr_clk) begin
        if (wr_rst_n && wr_en && !full_prev) model_q.push_back(wr_data);
        full_prev = wr_full;
    end

    // Read-side model: compare delivered words and ignored reads.
    always @(negedge rd_clk) begin
        if (rd_rst_n && rd_en) begin
            if (!empty_prev) begin
                if (model_q.size() == 0) begin
                    chk(1'b0, "R7", "read accepted with nothing stored", 1, 0);
                end else begin
                    logic [DATA_W-1:0] exp_w;
                    exp_w = model_q.pop_front();
                    chk(rd_data == exp_w, "R2/R3", "delivered word", rd_data, exp_w);
                end
            end else begin
                chk(rd_data == data_prev, "R6", "rd_data on read while empty", rd_data, data_prev);
            end
        end
        empty_prev = rd_empty;
        data_prev  = rd_data;
    end

    // Watchdog: a hung run is a failure.
    always @(posedge wr_clk) begin
        wr_cyc++;
        if (wr_cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", wr_cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk); #1;
            wr_en = 1'b1; wr_data = DATA_W'(wr_seq); wr_seq++;
        end
        @(negedge wr_clk); #1 wr_en = 1'b0;
    endtask

    task automatic read_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk); #1 rd_en = 1'b1;
        end
        @(negedge rd_clk); #1 rd_en = 1'b0;
    endtask

    task automatic run_phase(input real half, input int wpct, input int rpct, input int ncyc);
        bit wdone;
        wdone   = 1'b0;
        rd_half = half;
        repeat (4) @(negedge wr_clk);
        fork
            begin
                for (int c = 0; c < ncyc; c++) begin
                    @(negedge wr_clk); #1;
                    wr_en   = ($urandom_range(0, 99) < wpct);
                    wr_data = DATA_W'(wr_seq); wr_seq++;
                end
                @(negedge wr_clk); #1 wr_en = 1'b0;
                wdone = 1'b1;
            end
            begin
                while (!wdone) begin
                    @(negedge rd_clk); #1 rd_en = ($urandom_range(0, 99) < rpct);
                end
                read_burst(DEPTH * 4 + 20);
            end
        join
        repeat (4) @(negedge rd_clk);
        chk(model_q.size() == 0, "R2", "words left undelivered after phase", model_q.size(), 0);
    endtask

    initial begin
        int n;
        #203;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;

        // R1: state after reset
        @(negedge wr_clk);
        chk(wr_full == 1'b0, "R1", "wr_full after reset", wr_full, 0);
        chk(rd_empty == 1'b1, "R1", "rd_empty after reset", rd_empty, 1);
        chk(rd_data == '0, "R1", "rd_data after reset", rd_data, 0);

        // R4: fill with no reads; full exactly at DEPTH
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wr_clk);
            if (i == DEPTH - 1) chk(wr_full == 1'b0, "R4", "wr_full after DEPTH-1 writes", wr_full, 0);
            #1 wr_en = 1'b1; wr_data = DATA_W'(wr_seq); wr_seq++;
        end
        @(negedge wr_clk);
        chk(wr_full == 1'b1, "R4", "wr_full after DEPTH writes", wr_full, 1);

        // R5: three more writes with marker data while full
        for (int j = 0; j < 3; j++) begin
            #1 wr_data = DATA_W'(8'hE0 + j);
            @(negedge wr_clk);
        end
        #1 wr_en = 1'b0;
        #2 chk(model_q.size() == DEPTH, "R5", "stored count after writes while full", model_q.size(), DEPTH);

        // Drain, including reads past empty (R6 in the monitor)
        read_burst(DEPTH + 8);
        repeat (2) @(negedge rd_clk);
        chk(model_q.size() == 0, "R5", "words delivered after drain", model_q.size(), 0);
        chk(rd_empty == 1'b1, "R5", "rd_empty after drain", rd_empty, 1);

        // R8: empty clears within SYNC+1 read cycles of the write edge
        @(negedge wr_clk); #1 wr_en = 1'b1; wr_data = DATA_W'(wr_seq); wr_seq++;
        @(posedge wr_clk);
        fork begin @(negedge wr_clk); #1 wr_en = 1'b0; end join_none
        n = 0;
        do begin @(negedge rd_clk); n++; end while (rd_empty && n < 20);
        chk(n <= SYNC + 1, "R8", "read cycles until rd_empty falls", n, SYNC + 1);
        read_burst(1);
        repeat (SYNC + 3) @(negedge rd_clk);

        // R8: full clears within SYNC+1 write cycles of the read edge
        write_burst(DEPTH);
        chk(wr_full == 1'b1, "R4", "wr_full after refill", wr_full, 1);
        repeat (SYNC + 3) @(negedge rd_clk);
        @(negedge rd_clk); #1 rd_en = 1'b1;
        @(posedge rd_clk);
        fork begin @(negedge rd_clk); #1 rd_en = 1'b0; end join_none
        n = 0;
        do begin @(negedge wr_clk); n++; end while (wr_full && n < 20);
        chk(n <= SYNC + 1, "R8", "write cycles until wr_full falls", n, SYNC + 1);
        read_burst(DEPTH + 4);
        repeat (2) @(negedge rd_clk);
        chk(model_q.size() == 0, "R2", "words left after directed tests", model_q.size(), 0);

        // Random traffic at 1:3, 3:1 and near 1:1 read:write clock ratios
        run_phase(30.0, 35, 90, 3000);
        run_phase(3.333, 80, 30, 3000);
        run_phase(10.3, 55, 55, 3000);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule